// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of parameterised width W over several clock cycles, using radix-2 Booth recoding. A one-cycle start pulse captures both operands. The block then works through one recoding step per clock. Each step inspects the low bit of the working multiplier together with a guard bit that holds the bit shifted out by the previous step. From that pair it adds the multiplicand to the upper half of the working register, subtracts it, or leaves the upper half unchanged. The whole register is then shifted right by one place, and the sign is copied into the top on every shift.

The block makes exactly W such steps. It then registers the 2W-bit signed product and raises done for one clock. The result needs no correction pass for negative operands. The product stays on its port until the next accepted start. Start requests that arrive while a multiplication is running are dropped.

Top module: `booth_seq_mult`

## Requirements
- R1: While rst is high at a clock edge, busy, done and product are all 0 after that edge.
- R2: A start sampled high while busy is low captures both operands, and busy is high after that same edge.
- R3: The result is ready exactly W clock edges after the edge that accepted start. On that edge done goes high for exactly one cycle and busy goes low.
- R4: For every pair of W-bit signed operands, product read as a 2W-bit signed value equals multiplicand times multiplier.
- R5: The most negative operand value gives the exact product as multiplicand, as multiplier and as both (at W=4, -8 times -8 gives 64 and -8 times 7 gives -56).
- R6: At W=4, 2 times 6 gives 12 and 2 times -3 gives -6.
- R7: A start that is high while busy is high has no effect: the running result is unchanged and no extra done pulse follows.
- R8: product keeps its value from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; used only when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| product | output | 2W | Signed product, held until the next accepted start |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when product is updated |

## Verification
The bench builds the block twice, with W=4 and with W=8. At W=4 the operand space is small enough to run every one of the 256 pairs, so each recoding pattern and each placement of the most negative value is reached. The W=8 instance runs a table of extreme pairs and a few hundred random pairs. These cover long runs of ones and a wider sign extension, and they check that the latency follows the parameter.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      lsb,
  input  logic      guard,
  output booth_op_e op
);
  always_comb begin
    unique case ({lsb, guard})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_SKIP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] upper,
  input  logic [W:0]   mc_pos,
  input  logic [W:0]   mc_neg,
  input  booth_op_e    op,
  output logic [W:0]   sum
);
  logic [W:0] upper_ext;
  logic [W:0] operand;

  assign upper_ext = {upper[W-1], upper};

  always_comb begin
    unique case (op)
      OP_ADD:  operand = mc_pos;
      OP_SUB:  operand = mc_neg;
      default: operand = '0;
    endcase
  end

  assign sum = upper_ext + operand;
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  logic [CW-1:0] count;

  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (count == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      count <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy  <= 1'b1;
        count <= '0;
      end else if (busy) begin
        count <= count + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic [2*W-1:0] product,
  output logic         busy,
  output logic         done
);
  localparam int PW = 2 * W;

  logic [W-1:0] upper_q;
  logic [W-1:0] lower_q;
  logic         guard_q;
  logic [W:0]   mc_pos_q;
  logic [W:0]   mc_neg_q;

  logic      load, step, last;
  booth_op_e op;
  logic [W:0] sum;
  logic [W:0] mc_ext;

  assign mc_ext = {mcand[W-1], mcand};

  booth_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  booth_recoder u_rec (
    .lsb   (lower_q[0]),
    .guard (guard_q),
    .op    (op)
  );

  booth_addsub #(.W(W)) u_add (
    .upper  (upper_q),
    .mc_pos (mc_pos_q),
    .mc_neg (mc_neg_q),
    .op     (op),
    .sum    (sum)
  );

  // Arithmetic right shift of {sum, lower, guard}: the dropped bit is the guard.
  logic [W-1:0] upper_nx;
  logic [W-1:0] lower_nx;
  assign upper_nx = sum[W:1];
  assign lower_nx = {sum[0], lower_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q  <= '0;
      lower_q  <= '0;
      guard_q  <= 1'b0;
      mc_pos_q <= '0;
      mc_neg_q <= '0;
      product  <= '0;
    end else if (load) begin
      upper_q  <= '0;
      lower_q  <= mplier;
      guard_q  <= 1'b0;
      mc_pos_q <= mc_ext;
      mc_neg_q <= (~mc_ext) + 1'b1;
    end else if (step) begin
      upper_q <= upper_nx;
      lower_q <= lower_nx;
      guard_q <= lower_q[0];
      if (last) product <= PW'({upper_nx, lower_nx});
    end
  end
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2*W-1:0] product,
  input logic         busy,
  input logic         done
);
  localparam int CW = $clog2(W + 1) + 1;
  logic [CW-1:0] steps;

  always_ff @(posedge clk) begin
    if (rst) steps <= '0;
    else if (start && !busy) steps <= '0;
    else if (busy) steps <= steps + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !done && product == '0)); // R1
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy))); // R3
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst) done |-> (steps == CW'(W))); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (busy && start && steps < CW'(W - 1)) |=> busy); // R7
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(product)); // R8
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .product (product),
  .busy    (busy),
  .done    (done)
);

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [7:0] V_A [0:NV-1] = '{8'd127, 8'h80, 8'h80, 8'd0, 8'hFF, 8'd100, 8'hB3, 8'd85};
  localparam logic [7:0] V_B [0:NV-1] = '{8'd127, 8'h80, 8'd127, 8'hC9, 8'hFF, 8'hFD, 8'd45, 8'h80};
  localparam int V_P [0:NV-1] = '{16129, 16384, -16256, 0, 1, -300, -3465, -10880};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start4 = 1'b0, start8 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic [7:0] a8 = '0, b8 = '0;
  logic [7:0] p4;
  logic [15:0] p8;
  logic busy4, done4, busy8, done8;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_seq_mult #(.W(4)) uut (
    .clk(clk), .rst(rst), .start(start4), .mcand(a4), .mplier(b4),
    .product(p4), .busy(busy4), .done(done4));

  booth_seq_mult #(.W(8)) uut8 (
    .clk(clk), .rst(rst), .start(start8), .mcand(a8), .mplier(b8),
    .product(p8), .busy(busy8), .done(done8));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run4(input int a, input int b, input string req, input bit timing);
    int cyc;
    @(negedge clk);
    a4 = a[3:0]; b4 = b[3:0]; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    cyc = 1;
    if (timing) chk(busy4 == 1'b1, "R2 busy after start", busy4, 1);
    while (!done4 && cyc < 20) begin @(negedge clk); cyc++; end
    if (timing) chk(cyc == 5, "R3 latency W=4", cyc, 5);
    chk($signed(p4) == a * b, req, $signed(p4), a * b);
  endtask

  task automatic run8(input int a, input int b, input string req);
    int cyc;
    @(negedge clk);
    a8 = a[7:0]; b8 = b[7:0]; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    cyc = 1;
    while (!done8 && cyc < 30) begin @(negedge clk); cyc++; end
    chk(cyc == 9, "R3 latency W=8", cyc, 9);
    chk($signed(p8) == a * b, req, $signed(p8), a * b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy4 == 0 && done4 == 0, "R1 flags W=4", {busy4, done4}, 0);
    chk(p4 == 0, "R1 product W=4", p4, 0);
    chk(busy8 == 0 && done8 == 0 && p8 == 0, "R1 state W=8", p8, 0);
    rst = 1'b0;

    // R6: worked examples
    run4(2, 6, "R6 2*6", 1'b1);
    run4(2, -3, "R6 2*-3", 1'b1);
    // R5: most negative operand
    run4(-8, -8, "R5 -8*-8", 1'b0);
    run4(-8, 7, "R5 -8*7", 1'b0);
    run4(7, -8, "R5 7*-8", 1'b0);

    // R4: every pair at W=4
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        run4(a, b, "R4 exhaustive W=4", 1'b0);

    // R4/R5: vector table at W=8
    for (int i = 0; i < NV; i++)
      run8($signed(V_A[i]), $signed(V_B[i]), "R4 table W=8");
    // R4: random pairs at W=8
    for (int i = 0; i < 300; i++) begin
      automatic int ra = $signed(8'($urandom));
      automatic int rb = $signed(8'($urandom));
      run8(ra, rb, "R4 random W=8");
    end

    // R7: start while busy is ignored
    @(negedge clk);
    a4 = 4'd3; b4 = 4'd5; start4 = 1'b1;
    @(negedge clk);
    a4 = 4'd7; b4 = 4'd7;
    @(negedge clk);
    @(negedge clk);
    start4 = 1'b0;
    while (!done4) @(negedge clk);
    chk($signed(p4) == 15, "R7 result unaffected", $signed(p4), 15);
    @(negedge clk);
    chk(done4 == 0, "R3 done one cycle", done4, 0);
    begin
      automatic int extra = 0;
      repeat (8) begin
        if (done4 || busy4) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R7 no extra run", extra, 0);
    end

    // R8: product holds while idle, even with operands moving
    a4 = 4'd1; b4 = 4'd1;
    repeat (5) @(negedge clk);
    chk($signed(p4) == 15, "R8 product held", $signed(p4), 15);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule